// File: doc/BRIEF.md
# Prioritized Vectoring Interrupt Controller

This block collects thirteen level-sensitive interrupt request lines, numbered 1 to 13, and presents the most urgent unmasked one to the processor as a 3-bit interrupt level and an 8-bit vector number. Each source owns an 8-bit control byte. Bit 7 selects autovectoring. Bits [4:2] give the level and bits [1:0] give a sub-priority. Together, bits [4:0] form a 5-bit urgency code. A 16-bit mask word blocks individual sources. A read-only pending word shows the sampled request lines.

Software programs the block through a simple register bus with one write strobe and a combinational read port. Three vector registers supply vector numbers for sources that do not use autovectoring: one for the watchdog source (8) and one for each of the two serial sources (12 and 13). Acknowledge cycles are handled elsewhere.

The outputs are registered. A small presentation state machine has two states. ST_QUIET means no request is shown. ST_ACTIVE means a level and vector are being driven. It moves from ST_QUIET to ST_ACTIVE on TR_RAISE, when a qualifying winner exists. It moves from ST_ACTIVE back to ST_QUIET on TR_DROP, when none remains. It stays in ST_ACTIVE on TR_RESELECT, where the presented level and vector are reloaded every cycle.

Top module: `irqc_vector_ctrl`

## Requirements
- R1: Pending bit n (n = 1..13) equals the value of request line n sampled at the previous rising clock edge. The pending word reads at address 0x3A with source n in bit n; bits 0, 14 and 15 read as 0.
- R2: A source takes part in arbitration only when its pending bit is 1 and its mask bit (bit n of the mask word) is 0.
- R3: Among the active sources, the one with the largest control bits [4:0] wins. On equal values, the lowest source number wins.
- R4: If no source is active, or the winning [4:0] value is below 4, both outputs are 0.
- R5: The presented level equals control bits [4:2] of the winner.
- R6: If control bit 7 of the winner is 1, the vector is 24 plus the presented level.
- R7: If control bit 7 of the winner is 0, the vector comes from a fixed table. Source 8 takes the watchdog vector register (0x42). Source 12 takes the first serial vector register (0x44). Source 13 takes the second serial vector register (0x45). Every other source gives 0x0F.
- R8: After reset, the control bytes for sources 1..13 are 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00 and 0x00. The mask is 0x3FFE, the watchdog vector is 0x0F, both serial vectors are 0x00, and both outputs are 0.
- R9: The control byte of source n is written from wdata[7:0] and read back at address 0x13+n. The mask word is written and read in full at address 0x36. The vector registers are written from wdata[7:0] and read back.
- R10: A write to the pending address changes neither the pending word nor the outputs.
- R11: A change to the mask, a control byte or a pending bit reaches the outputs exactly one clock after the register changes. A request line therefore reaches the outputs two clocks after it changes.
- R12: A vector register write changes the presented vector one clock after the register updates. It never changes the presented level.
- R13: Reads from unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src | input | 13 | Request lines, bit n is source n |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_level | output | 3 | Presented interrupt level, 0 when idle |
| irq_vector | output | 8 | Presented vector number, 0 when idle |

## Verification
The assertions take for granted that the request lines and bus inputs are synchronous to clk and stable around its rising edge. They also assume the pending sampler sees every level the lines hold for a full cycle. The bench therefore changes every input only on the falling edge, holds each write for exactly one rising edge, and never pulses a request line for less than a cycle. The assertions further assume that reads have no side effect. The bench accordingly reads freely while it waits for the registered outputs to settle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ADDR_CTRL_BASE = 'h13;
    localparam int ADDR_MASK      = 'h36;
    localparam int ADDR_PEND      = 'h3A;
    localparam int ADDR_WDOG_VEC  = 'h42;
    localparam int ADDR_UARTA_VEC = 'h44;
    localparam int ADDR_UARTB_VEC = 'h45;

    localparam int SRC_WDOG   = 8;
    localparam int SRC_UART_A = 12;
    localparam int SRC_UART_B = 13;

    localparam logic [7:0]  VEC_UNKNOWN   = 8'h0F;
    localparam logic [7:0]  VEC_AUTO_BASE = 8'd24;
    localparam logic [4:0]  CODE_FLOOR    = 5'd4;
    localparam logic [15:0] MASK_RESET    = 16'h3FFE;
    localparam logic [7:0]  WDOG_RESET    = 8'h0F;

    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_ACTIVE = 1'b1
    } present_e;

    typedef struct packed {
        logic       auto_vec;
        logic [4:0] code;
    } pri_t;

    function automatic logic [7:0] ctrl_reset(input int n);
        if (n <= 7)       return 8'(4 * n);
        else if (n == 8)  return 8'h1C;
        else if (n <= 11) return 8'h80;
        else              return 8'h00;
    endfunction

endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int NUM_SRC = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   src_in,
    output logic [NUM_SRC:1]   pend_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= src_in;
    end

    assert_pend_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q == $past(src_in)));

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int RW      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    input  logic [RW-1:0]          pend_word,
    output logic [DW-1:0]          bus_rdata,
    output pri_t [NUM_SRC:1]       pri,
    output logic [RW-1:0]          mask_q,
    output logic [7:0]             wdog_vec_q,
    output logic [7:0]             uarta_vec_q,
    output logic [7:0]             uartb_vec_q
);

    localparam logic [AW-1:0] A_MASK  = AW'(ADDR_MASK);
    localparam logic [AW-1:0] A_PEND  = AW'(ADDR_PEND);
    localparam logic [AW-1:0] A_WDOG  = AW'(ADDR_WDOG_VEC);
    localparam logic [AW-1:0] A_UARTA = AW'(ADDR_UARTA_VEC);
    localparam logic [AW-1:0] A_UARTB = AW'(ADDR_UARTB_VEC);

    logic [NUM_SRC:1][7:0] ctrl_q;

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_ctrl
        localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL_BASE + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          ctrl_q[g] <= ctrl_reset(g);
            else if (bus_we && bus_addr == A_CTRL) ctrl_q[g] <= bus_wdata[7:0];
        end
        assign pri[g].auto_vec = ctrl_q[g][7];
        assign pri[g].code     = ctrl_q[g][4:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q      <= MASK_RESET;
            wdog_vec_q  <= WDOG_RESET;
            uarta_vec_q <= 8'h00;
            uartb_vec_q <= 8'h00;
        end else if (bus_we) begin
            if (bus_addr == A_MASK)  mask_q      <= RW'(bus_wdata);
            if (bus_addr == A_WDOG)  wdog_vec_q  <= bus_wdata[7:0];
            if (bus_addr == A_UARTA) uarta_vec_q <= bus_wdata[7:0];
            if (bus_addr == A_UARTB) uartb_vec_q <= bus_wdata[7:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (bus_addr == AW'(ADDR_CTRL_BASE + i)) bus_rdata = DW'(ctrl_q[i]);
        end
        if (bus_addr == A_MASK)  bus_rdata = DW'(mask_q);
        if (bus_addr == A_PEND)  bus_rdata = DW'(pend_word);
        if (bus_addr == A_WDOG)  bus_rdata = DW'(wdog_vec_q);
        if (bus_addr == A_UARTA) bus_rdata = DW'(uarta_vec_q);
        if (bus_addr == A_UARTB) bus_rdata = DW'(uartb_vec_q);
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int IW      = $clog2(NUM_SRC + 1)
) (
    input  pri_t [NUM_SRC:1]   pri,
    input  logic [NUM_SRC:1]   pend,
    input  logic [NUM_SRC:1]   mask,
    output logic               win_valid,
    output logic [IW-1:0]      win_idx,
    output logic [4:0]         win_code,
    output logic [2:0]         win_level,
    output logic               win_auto
);

    logic [4:0]    best;
    logic [IW-1:0] best_idx;
    logic          best_auto;

    // Ascending scan with strict compare: the first source at the top code keeps it.
    always_comb begin
        best      = '0;
        best_idx  = '0;
        best_auto = 1'b0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (pend[i] && !mask[i] && (pri[i].code > best)) begin
                best      = pri[i].code;
                best_idx  = IW'(i);
                best_auto = pri[i].auto_vec;
            end
        end
    end

    assign win_valid = (best >= CODE_FLOOR);
    assign win_idx   = best_idx;
    assign win_code  = best;
    assign win_level = best[4:2];
    assign win_auto  = best_auto;

endmodule

// File: rtl/irqc_vector_sel.sv
module irqc_vector_sel
    import irqc_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          win_valid,
    input  logic [IW-1:0] win_idx,
    input  logic [2:0]    win_level,
    input  logic          win_auto,
    input  logic [7:0]    wdog_vec,
    input  logic [7:0]    uarta_vec,
    input  logic [7:0]    uartb_vec,
    output logic [2:0]    req_level,
    output logic [7:0]    req_vector
);

    always_comb begin
        req_level  = 3'd0;
        req_vector = 8'd0;
        if (win_valid) begin
            req_level = win_level;
            if (win_auto) begin
                req_vector = VEC_AUTO_BASE + {5'd0, win_level};
            end else if (win_idx == IW'(SRC_WDOG)) begin
                req_vector = wdog_vec;
            end else if (win_idx == IW'(SRC_UART_A)) begin
                req_vector = uarta_vec;
            end else if (win_idx == IW'(SRC_UART_B)) begin
                req_vector = uartb_vec;
            end else begin
                req_vector = VEC_UNKNOWN;
            end
        end
    end

endmodule

// File: rtl/irqc_vector_ctrl.sv
module irqc_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int AW      = 8,
    parameter int DW      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   irq_src,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic [2:0]         irq_level,
    output logic [7:0]         irq_vector
);

    localparam int RW = 16;
    localparam int IW = $clog2(NUM_SRC + 1);

    logic [NUM_SRC:1] pend_src;
    logic [RW-1:0]    pend_word;
    pri_t [NUM_SRC:1] pri;
    logic [RW-1:0]    mask_word;
    logic [7:0]       wdog_vec, uarta_vec, uartb_vec;
    logic             win_valid, win_auto;
    logic [IW-1:0]    win_idx;
    logic [4:0]       win_code;
    logic [2:0]       win_level, req_level;
    logic [7:0]       req_vector;
    present_e         state_q, state_d;

    irqc_pending #(.NUM_SRC(NUM_SRC)) u_pending (
        .clk(clk), .rst_n(rst_n), .src_in(irq_src), .pend_q(pend_src)
    );

    assign pend_word = RW'({pend_src, 1'b0});

    irqc_regfile #(.NUM_SRC(NUM_SRC), .AW(AW), .DW(DW), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pend_word(pend_word), .bus_rdata(bus_rdata),
        .pri(pri), .mask_q(mask_word), .wdog_vec_q(wdog_vec),
        .uarta_vec_q(uarta_vec), .uartb_vec_q(uartb_vec)
    );

    irqc_arbiter #(.NUM_SRC(NUM_SRC), .IW(IW)) u_arb (
        .pri(pri), .pend(pend_src), .mask(mask_word[NUM_SRC:1]),
        .win_valid(win_valid), .win_idx(win_idx), .win_code(win_code),
        .win_level(win_level), .win_auto(win_auto)
    );

    irqc_vector_sel #(.IW(IW)) u_vsel (
        .win_valid(win_valid), .win_idx(win_idx), .win_level(win_level),
        .win_auto(win_auto), .wdog_vec(wdog_vec), .uarta_vec(uarta_vec),
        .uartb_vec(uartb_vec), .req_level(req_level), .req_vector(req_vector)
    );

    // Presentation state machine: TR_RAISE, TR_RESELECT, TR_DROP.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  state_d = win_valid ? ST_ACTIVE : ST_QUIET;
            ST_ACTIVE: state_d = win_valid ? ST_ACTIVE : ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_level  <= 3'd0;
            irq_vector <= 8'd0;
        end else if (state_d == ST_ACTIVE) begin
            irq_level  <= req_level;
            irq_vector <= req_vector;
        end else begin
            irq_level  <= 3'd0;
            irq_vector <= 8'd0;
        end
    end

    assert_win_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (pend_word[win_idx] && !mask_word[win_idx]));

    assert_win_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_code >= CODE_FLOOR));

    assert_quiet_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == 3'd0) |-> (irq_vector == 8'd0));

    assert_state_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) == (irq_level != 3'd0));

    assert_level_only_regs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pend_src) && $stable(mask_word) && $stable(pri)) |=> $stable(irq_level));

endmodule

// File: tb/irqc_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irqc_vector_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:1] irq_src = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0]  m_ctrl [1:13];
    logic [15:0] m_mask;
    logic [7:0]  m_wd, m_ua, m_ub;

    always #4 clk = ~clk;

    irqc_vector_ctrl u_irqc_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr_ctrl(input int n, input logic [7:0] v);
        m_ctrl[n] = v;
        wr(8'(8'h13 + n), {8'h00, v});
    endtask

    task automatic wr_mask(input logic [15:0] v);
        m_mask = v;
        wr(8'h36, v);
    endtask

    // Expected {level, vector} from R2..R7.
    function automatic logic [10:0] expect_out();
        logic [4:0] best = 0;
        int win = 0;
        logic [2:0] lv;
        logic [7:0] vc;
        for (int i = 1; i <= 13; i++)
            if (irq_src[i] && !m_mask[i] && m_ctrl[i][4:0] > best) begin
                best = m_ctrl[i][4:0]; win = i;
            end
        if (best < 4) return 11'd0;
        lv = best[4:2];
        if (m_ctrl[win][7]) vc = 8'd24 + 8'(lv);
        else if (win == 8)  vc = m_wd;
        else if (win == 12) vc = m_ua;
        else if (win == 13) vc = m_ub;
        else                vc = 8'h0F;
        return {lv, vc};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [10:0] e;
        for (int i = 1; i <= 13; i++)
            m_ctrl[i] = (i <= 7) ? 8'(4 * i) : (i == 8) ? 8'h1C : (i <= 11) ? 8'h80 : 8'h00;
        m_mask = 16'h3FFE; m_wd = 8'h0F; m_ua = 8'h00; m_ub = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        chk("R8 level", 32'(irq_level), 0);
        chk("R8 vector", 32'(irq_vector), 0);
        for (int i = 1; i <= 13; i++) begin
            rd(8'(8'h13 + i), d);
            chk("R8 ctrl", 32'(d), 32'(m_ctrl[i]));
        end
        rd(8'h36, d); chk("R8 mask", 32'(d), 32'h3FFE);
        rd(8'h42, d); chk("R8 wdog vec", 32'(d), 32'h0F);
        rd(8'h44, d); chk("R8 uart a vec", 32'(d), 0);
        rd(8'h45, d); chk("R8 uart b vec", 32'(d), 0);
        rd(8'h3A, d); chk("R8 pending", 32'(d), 0);

        // R13: unmapped reads
        rd(8'h00, d); chk("R13 addr 00", 32'(d), 0);
        rd(8'h30, d); chk("R13 addr 30", 32'(d), 0);
        rd(8'h21, d); chk("R13 addr 21", 32'(d), 0);

        // R9: register readback
        wr(8'h44, 16'h0061); m_ua = 8'h61;
        wr(8'h45, 16'h0062); m_ub = 8'h62;
        rd(8'h44, d); chk("R9 uart a vec", 32'(d), 32'h61);
        rd(8'h45, d); chk("R9 uart b vec", 32'(d), 32'h62);
        wr_mask(16'hA5C3);
        rd(8'h36, d); chk("R9 mask", 32'(d), 32'hA5C3);
        wr_ctrl(5, 8'hE7);
        rd(8'h18, d); chk("R9 ctrl 5", 32'(d), 32'hE7);

        // R1, R11: pending sampling and latency
        wr_mask(16'h0000);
        for (int i = 1; i <= 13; i++) wr_ctrl(i, 8'h00);
        wr_ctrl(6, 8'h0D);
        @(negedge clk);
        irq_src = 13'b0;
        irq_src[6] = 1'b1;
        @(negedge clk);
        rd(8'h3A, d); chk("R1 pending bit 6", 32'(d), 32'h0040);
        chk("R11 level not yet", 32'(irq_level), 0);
        @(negedge clk);
        chk("R11 level after two", 32'(irq_level), 3);
        chk("R11 vector after two", 32'(irq_vector), 32'h0F);
        irq_src = '1;
        @(negedge clk);
        rd(8'h3A, d); chk("R1 pending all", 32'(d), 32'h3FFE);

        // R10: pending is read-only
        wr(8'h3A, 16'h0000);
        rd(8'h3A, d); chk("R10 pending kept", 32'(d), 32'h3FFE);
        @(negedge clk);
        chk("R10 level kept", 32'(irq_level), 3);

        // R11: mask write reaches outputs one clock after update
        wr_mask(16'h0040);
        chk("R11 mask not yet", 32'(irq_level), 3);
        @(negedge clk);
        chk("R11 mask applied", 32'(irq_level), 0);

        // R12: vector register write changes vector, not level
        wr_mask(16'h0000);
        for (int i = 1; i <= 13; i++) wr_ctrl(i, 8'h00);
        wr_ctrl(8, 8'h19);
        @(negedge clk);
        chk("R7 wdog vec", 32'(irq_vector), 32'h0F);
        wr(8'h42, 16'h0055); m_wd = 8'h55;
        chk("R12 level held", 32'(irq_level), 6);
        chk("R12 vector not yet", 32'(irq_vector), 32'h0F);
        @(negedge clk);
        chk("R12 level same", 32'(irq_level), 6);
        chk("R12 vector new", 32'(irq_vector), 32'h55);

        // R4, R5, R6, R7: single source, every code, both vector modes
        for (int s = 1; s <= 13; s++) begin
            for (int i = 1; i <= 13; i++) wr_ctrl(i, 8'h00);
            irq_src = '0;
            irq_src[s] = 1'b1;
            for (int v = 0; v < 64; v++) begin
                wr_ctrl(s, 8'(((v & 32) << 2) | (v & 31)));
                @(negedge clk);
                e = expect_out();
                chk("R5 level sweep", 32'(irq_level), 32'(e[10:8]));
                chk((v & 32) != 0 ? "R6 auto vector sweep" : "R7 R4 vector sweep",
                    32'(irq_vector), 32'(e[7:0]));
            end
        end

        // R3: all sources active, patterns with many ties
        irq_src = '1;
        @(negedge clk);
        for (int k = 0; k < 64; k++) begin
            for (int i = 1; i <= 13; i++)
                wr_ctrl(i, 8'(((i % 2) << 7) | ((i * k * 7 + k) % 32 & ~((k % 3) == 0 ? 3 : 0))));
            @(negedge clk);
            e = expect_out();
            chk("R3 priority pattern", 32'({irq_level, irq_vector}), 32'(e));
        end
        for (int i = 1; i <= 13; i++) wr_ctrl(i, 8'h00);
        wr_ctrl(12, 8'h18);
        wr_ctrl(8, 8'h18);
        @(negedge clk);
        chk("R3 tie to lower source", 32'(irq_vector), 32'h55);

        // R2: exhaustive mask sweep over the thirteen source bits
        for (int i = 1; i <= 13; i++) wr_ctrl(i, 8'(((i * 11) % 28) + 4 | ((i % 3 == 0) ? 8'h80 : 8'h00)));
        for (int k = 0; k < 8192; k++) begin
            wr_mask(16'(k << 1));
            @(negedge clk);
            e = expect_out();
            chk("R2 mask sweep", 32'({irq_level, irq_vector}), 32'(e));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule